// File: doc/BRIEF.md
# Page Write Buffer with Programming Timer

This block sits between a serial target engine and a non-volatile memory array. The engine hands it a start address, then a stream of data bytes. Each byte lands in a 16-byte page latch. The column part of the address advances after every byte and wraps inside the page, while the row part stays where it was set. A per-column valid mask records which columns actually received a byte.

When the engine reports a stop condition, the block looks at the write-protect input at that moment. If writing is allowed and at least one byte is latched, it starts a self-timed programming cycle. During that cycle it raises `busy` for a fixed number of system clocks. The target engine uses `busy` to withhold its acknowledge of the device address, which is how a host polls for completion.

While busy, the block walks the page from column 0 to the last column, one column per clock. It emits a memory write only for the columns that were loaded. During the busy period every input is ignored, and when the cycle ends the block returns to idle with an empty latch.

Top module: `pwb_top`

## Requirements
- R1: After reset `busy` is 0 and `mem_we` is 0.
- R2: A start-address load sets the row (address bits above the low 4) and the column (low 4 bits). Successive bytes go to successive columns. Every committed write carries that row unchanged in `mem_addr`. The write for column c appears on the memory port c+1 clocks after the clock edge that samples the accepted stop, and columns are written in ascending order.
- R3: After the last column the column pointer wraps to column 0. A byte loaded more than 16 positions after the first overwrites the earlier byte in the same column, and only the latest value is committed.
- R4: Only columns that received a byte since the last start-address load are written, each exactly once per programming cycle. No write appears outside a programming cycle.
- R5: `busy` rises on the clock edge that samples an accepted stop and stays high for exactly PROG_CYCLES clocks (PROG_CYCLES is raised to PAGE_BYTES+1 if set lower).
- R6: While `busy` is high, address loads, byte loads and stops have no effect. After the cycle ends, a stop with no new bytes starts no cycle and produces no write.
- R7: If `wp` is 1 in the cycle the stop is sampled, no cycle starts and the latched bytes are discarded, so a following stop with `wp` at 0 starts nothing.
- R8: A stop with no byte latched (for example after an address-only transfer) starts no cycle.
- R9: A start-address load discards all bytes latched before it.
- R10: `wp` is only looked at when the stop is sampled; its level while bytes are loaded does not matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_addr_vld | input | 1 | Start-address load strobe |
| ld_addr | input | ADDR_W | Start address: row in upper bits, column in low log2(PAGE_BYTES) bits |
| byte_vld | input | 1 | Data byte strobe (ignored in a cycle with ld_addr_vld) |
| byte_data | input | DATA_W | Data byte |
| stop_evt | input | 1 | Stop condition strobe from the target engine |
| wp | input | 1 | Write protect, 1 blocks programming |
| busy | output | 1 | Programming cycle in progress |
| mem_we | output | 1 | Memory array write enable |
| mem_addr | output | ADDR_W | Memory array write address |
| mem_wdata | output | DATA_W | Memory array write data |

## Verification
With the stop sampled at edge k, `busy` must read high from edge k through edge k+PROG_CYCLES-1. It must read low from edge k+PROG_CYCLES onward, and the write for column c must be on the port after edge k+1+c. The bench stamps each expected write with that cycle number when it drives the stop. A monitor checks port values on the falling clock edge and compares the address, data and cycle stamp of every write it pops. The busy window length is counted at the same falling edges. Cases with no cycle are checked by watching `busy` for several clocks, and the monitor flags any write it did not expect.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  // The commit scan needs one clock per column plus one to finish, so the
  // programming window is never shorter than that.
  function automatic int pwb_prog_len(input int req_cycles, input int page_bytes);
    return (req_cycles > page_bytes) ? req_cycles : page_bytes + 1;
  endfunction

endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);

  // Data store carries no reset so it maps onto distributed RAM.
  logic [DATA_W-1:0]     store [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_col] <= wr_data;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst || clr)
        mask[g] <= 1'b0;
      else if (wr_en && (wr_col == COL_W'(g)))
        mask[g] <= 1'b1;
    end
  end

  assign rd_data   = store[rd_col];
  assign rd_valid  = mask[rd_col];
  assign any_valid = |mask;

endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
  parameter int PROG_LEN = 40,
  localparam int CNT_W   = $clog2(PROG_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        remain <= CNT_W'(PROG_LEN - 1);
      end
    end else if (remain == '0) begin
      busy <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int COL_W     = $clog2(PAGE_BYTES),
  localparam int ROW_W     = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  rd_col,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  logic [COL_W-1:0] idx;
  logic             run;

  assign rd_col = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      idx       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_we <= 1'b0;
      if (run) begin
        mem_we    <= rd_valid;
        mem_addr  <= {row, idx};
        mem_wdata <= rd_data;
        idx       <= idx + 1'b1;
        if (idx == LAST_COL) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        run <= 1'b1;
        idx <= '0;
      end
    end
  end

endmodule

// File: rtl/pwb_top.sv
module pwb_top #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_addr_vld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_evt,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int COL_W    = $clog2(PAGE_BYTES);
  localparam int ROW_W    = ADDR_W - COL_W;
  localparam int PROG_LEN = pwb_pkg::pwb_prog_len(PROG_CYCLES, PAGE_BYTES);

  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              addr_take, byte_take, stop_take, launch, clr_page;
  logic [COL_W-1:0]  scan_col;
  logic [DATA_W-1:0] scan_data;
  logic              scan_valid, page_any, scan_done;

  // Nothing is accepted while programming runs.
  assign addr_take = ld_addr_vld & ~busy;
  assign byte_take = byte_vld & ~ld_addr_vld & ~busy;
  assign stop_take = stop_evt & ~busy;
  assign launch    = stop_take & ~wp & page_any;
  assign clr_page  = addr_take | (stop_take & ~launch) | scan_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else if (addr_take) begin
      row_q <= ld_addr[ADDR_W-1:COL_W];
      col_q <= ld_addr[COL_W-1:0];
    end else if (byte_take) begin
      col_q <= col_q + 1'b1;
    end
  end

  pwb_page_latch #(
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_latch (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (byte_take),
    .wr_col   (col_q),
    .wr_data  (byte_data),
    .clr      (clr_page),
    .rd_col   (scan_col),
    .rd_data  (scan_data),
    .rd_valid (scan_valid),
    .any_valid(page_any)
  );

  pwb_prog_timer #(
    .PROG_LEN(PROG_LEN)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(launch),
    .busy (busy)
  );

  pwb_commit_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (launch),
    .row      (row_q),
    .rd_col   (scan_col),
    .rd_data  (scan_data),
    .rd_valid (scan_valid),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .done     (scan_done)
  );

endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int PROG_CYCLES = 40,
  parameter int PAGE_BYTES  = 16
) (
  input logic clk,
  input logic rst,
  input logic stop_evt,
  input logic wp,
  input logic busy,
  input logic mem_we
);

  localparam int PROG_LEN = pwb_pkg::pwb_prog_len(PROG_CYCLES, PAGE_BYTES);

  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= '0;
  end

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_evt && !wp));

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == 32'(PROG_LEN)));

  // R4
  write_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R7
  protect_block_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && wp && !busy) |=> !busy);

endmodule

bind pwb_top pwb_chk #(
  .PROG_CYCLES(PROG_CYCLES),
  .PAGE_BYTES (PAGE_BYTES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .stop_evt(stop_evt),
  .wp      (wp),
  .busy    (busy),
  .mem_we  (mem_we)
);

// File: tb/pwb_top_tb.sv
module pwb_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam int DATA_W     = 8;
  localparam int PAGE       = 16;
  localparam int COL_W      = 4;
  localparam int ROW_W      = ADDR_W - COL_W;
  localparam int PROG       = 40;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_addr_vld = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic              byte_vld = 1'b0;
  logic [DATA_W-1:0] byte_data = '0;
  logic              stop_evt = 1'b0;
  logic              wp = 1'b0;
  logic              busy, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  pwb_top #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)
  ) u_dut (
    .clk(clk), .rst(rst), .ld_addr_vld(ld_addr_vld), .ld_addr(ld_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt), .wp(wp),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    int                c;
    string             tag;
  } wr_t;

  wr_t exp_q[$];
  int  n_chk = 0;
  int  n_err = 0;
  bit  ended = 1'b0;

  // Reference page model built from the requirements.
  logic [DATA_W-1:0] m_data [PAGE];
  bit                m_mask [PAGE];
  logic [ROW_W-1:0]  m_row = '0;
  logic [COL_W-1:0]  m_col = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected write per observed write.
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected write at address", int'(mem_addr), -1);
      end else begin : pop
        wr_t it;
        it = exp_q.pop_front();
        chk(mem_addr == it.a, it.tag, "write address", int'(mem_addr), int'(it.a));
        chk(mem_wdata == it.d, it.tag, "write data", int'(mem_wdata), int'(it.d));
        chk(cyc == it.c, it.tag, "write cycle", cyc, it.c);
      end
    end
  end

  task automatic clear_model();
    for (int i = 0; i < PAGE; i++) m_mask[i] = 1'b0;
  endtask

  task automatic do_addr(input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col);
    ld_addr_vld = 1'b1;
    ld_addr     = {row, col};
    @(negedge clk);
    ld_addr_vld = 1'b0;
    m_row = row;
    m_col = col;
    clear_model();
  endtask

  task automatic do_byte(input logic [DATA_W-1:0] d);
    byte_vld  = 1'b1;
    byte_data = d;
    @(negedge clk);
    byte_vld = 1'b0;
    m_data[m_col] = d;
    m_mask[m_col] = 1'b1;
    m_col = m_col + 1'b1;
  endtask

  // Driver: issues a stop, pushes the expected writes, checks the busy window.
  task automatic do_stop(input bit w, input bit junk, input string tag);
    int  k;
    int  n;
    bit  any;
    any = 1'b0;
    for (int i = 0; i < PAGE; i++) any |= m_mask[i];
    wp       = w;
    stop_evt = 1'b1;
    k        = cyc + 1;
    if (any && !w) begin
      for (int c = 0; c < PAGE; c++) begin
        if (m_mask[c]) begin
          wr_t it;
          it.a   = {m_row, COL_W'(c)};
          it.d   = m_data[c];
          it.c   = k + 1 + c;
          it.tag = tag;
          exp_q.push_back(it);
        end
      end
    end
    clear_model();
    @(negedge clk);
    stop_evt = 1'b0;
    wp       = 1'b0;
    chk(busy == (any && !w), tag, "busy after stop", int'(busy), int'(any && !w));
    if (any && !w) begin
      n = 0;
      while (busy && n < 10 * PROG) begin
        n++;
        if (junk) begin
          ld_addr_vld = n[0];
          ld_addr     = 11'h7F5;
          byte_vld    = 1'b1;
          byte_data   = 8'(n);
          stop_evt    = n[1];
        end
        @(negedge clk);
      end
      ld_addr_vld = 1'b0;
      byte_vld    = 1'b0;
      stop_evt    = 1'b0;
      chk(n == PROG, "R5", "busy length", n, PROG);
    end else begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(busy == 1'b0, tag, "busy stays low", int'(busy), 0);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(mem_we == 1'b0, "R1", "mem_we after reset", int'(mem_we), 0);

    // R2: partial page starting mid-row
    do_addr(7'd5, 4'd3);
    do_byte(8'hA1); do_byte(8'hB2); do_byte(8'hC3);
    do_stop(1'b0, 1'b0, "R2");

    // R3: twenty bytes from column 14 wrap and overwrite
    do_addr(7'd7, 4'd14);
    for (int i = 0; i < 20; i++) do_byte(8'(8'h40 + i));
    do_stop(1'b0, 1'b0, "R3");

    // R4: single byte at last column, nothing else written
    do_addr(7'd100, 4'd15);
    do_byte(8'h5A);
    do_stop(1'b0, 1'b0, "R4");

    // R7: protected stop discards the latch
    do_addr(7'd9, 4'd0);
    do_byte(8'h11); do_byte(8'h22);
    do_stop(1'b1, 1'b0, "R7");
    do_stop(1'b0, 1'b0, "R7");

    // R8: address-only transfer
    do_addr(7'd3, 4'd8);
    do_stop(1'b0, 1'b0, "R8");

    // R9: new address drops earlier bytes
    do_addr(7'd1, 4'd0);
    do_byte(8'h91); do_byte(8'h92); do_byte(8'h93);
    do_addr(7'd2, 4'd9);
    do_byte(8'h99);
    do_stop(1'b0, 1'b0, "R9");

    // R10: write protect high while loading, low at stop
    wp = 1'b1;
    do_addr(7'd64, 4'd6);
    do_byte(8'hE0); do_byte(8'hE1);
    do_stop(1'b0, 1'b0, "R10");

    // R6: inputs during busy are ignored
    do_addr(7'd127, 4'd1);
    do_byte(8'h3C); do_byte(8'h4D);
    do_stop(1'b0, 1'b1, "R6");
    do_stop(1'b0, 1'b0, "R6");

    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "writes still pending", exp_q.size(), 0);
    finish_run();
  end

endmodule